// File: doc/BRIEF.md
# DMA Bus Handover Controller with Write Snooping

This block sits on the processor side of a shared address/data bus and decides who drives it. When an external DMA master raises its request, the controller lets the machine cycle in progress run to its boundary. At that boundary it turns off the address, data and control output enables, so those drivers go to high impedance, and raises an acknowledge. While the DMA master owns the bus, every DMA write address is compared against a small direct-mapped tag store of cached lines. A hit either invalidates that line or overwrites its data with the written value. A policy input picks which of the two happens.

When the request drops, the controller enters a one-clock reclaim step. In that step the enables come back on and the acknowledge falls together, and then it returns to normal ownership. The core is stalled through a hold output only while the bus is released, so it resumes its cycle sequence exactly where it stopped. The core fills lines through a fill port and reads them through a combinational lookup port. Each coherence action is reported one clock later on an event port.

The snoop port has no back-pressure. Its ready is implicitly always high, and one snoop is accepted every clock with no wait states. The fill port follows the same rule outside the released state.

Top module: `bus_handover_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts the block in the owning state: acknowledge low, all three output enables high, hold low, event low, and all 8 lines invalid so every lookup misses.
- R2: When the request is high and cycle-done is low, the enables stay high and acknowledge stays low. The bus is released at the first clock edge at which both request and cycle-done are high. If the request drops before that edge, the block stays owning.
- R3: While the bus is released, acknowledge is high and the address, data and control enables are all low. Cycle-done has no effect in this state.
- R4: At the first clock edge with the request low in the released state, acknowledge falls and all enables rise in the same cycle (reclaim). One clock later the block is owning again, and a request seen during reclaim is only acted on from the owning state.
- R5: The hold output to the core is high exactly while the bus is released.
- R6: A DMA write whose address hits a valid line while released, with policy 0 (invalidate), clears that line's valid bit.
- R7: A hit with policy 1 (update) keeps the line valid and replaces its data with the snooped write data.
- R8: A snoop with the write strobe low (a DMA read) and a write that misses leave every line unchanged and raise no event. A miss is an invalid line or a tag that differs. The line index is address bits [2:0] and the tag is the upper 13 bits.
- R9: Snoop writes outside the released state are ignored.
- R10: One clock after a snoop hit, the event valid output is high for one cycle, together with the line index and a kind bit (1 = update, 0 = invalidate).
- R11: A fill writes tag and data and sets the line valid when the bus is not released. A fill presented while released is ignored.
- R12: Snoop writes on back-to-back clocks are each handled, one per clock, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_req_i | input | 1 | Bus request from the DMA master, active high |
| cyc_done_i | input | 1 | Strobe from the core marking the last clock of a machine cycle |
| dma_ack_o | output | 1 | Bus acknowledge to the DMA master, active high |
| addr_oe_o | output | 1 | Address bus output enable |
| data_oe_o | output | 1 | Data bus output enable |
| ctrl_oe_o | output | 1 | Control line output enable |
| cpu_hold_o | output | 1 | Stall to the core while the bus is released |
| snoop_wr_i | input | 1 | DMA write strobe on the bus |
| snoop_addr_i | input | 16 | Bus address during DMA activity |
| snoop_data_i | input | 8 | Bus data during DMA activity |
| policy_upd_i | input | 1 | Coherence policy: 0 invalidate, 1 update |
| fill_valid_i | input | 1 | Core line fill strobe |
| fill_addr_i | input | 16 | Fill address |
| fill_data_i | input | 8 | Fill data |
| lk_addr_i | input | 16 | Lookup address |
| lk_hit_o | output | 1 | Lookup hits a valid line |
| lk_data_o | output | 8 | Data of the looked-up line |
| evt_valid_o | output | 1 | A coherence action happened on the previous clock |
| evt_line_o | output | 3 | Line index of that action |
| evt_upd_o | output | 1 | Action kind: 1 update, 0 invalidate |

## Verification
Bus reclaim and a snoop hit can fall in the same cycle. This happens when a DMA write is still on the bus during the clock in which the request drops. The bench provokes it by lowering the request and presenting a hitting write with invalidate policy in one clock. It expects the reclaim outputs (acknowledge low, enables high) and the event for that write on the next cycle, and a later lookup must show the line invalidated. A second overlap drives cycle-done together with a request drop while the request is still waiting for a cycle boundary, and expects the block to stay owning.

// File: rtl/bho_pkg.sv
package bho_pkg;
  typedef enum logic [1:0] {
    ST_OWNED    = 2'd0,
    ST_WAIT_END = 2'd1,
    ST_RELEASED = 2'd2,
    ST_RECLAIM  = 2'd3
  } bus_state_t;
endpackage

// File: rtl/bho_fsm.sv
module bho_fsm
  import bho_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_i,
  input  logic       cyc_done_i,
  output bus_state_t state_o,
  output logic       ack_o,
  output logic       oe_o,
  output logic       hold_o
);
  bus_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OWNED:    if (req_i) st_d = cyc_done_i ? ST_RELEASED : ST_WAIT_END;
      ST_WAIT_END: if (!req_i) st_d = ST_OWNED;
                   else if (cyc_done_i) st_d = ST_RELEASED;
      ST_RELEASED: if (!req_i) st_d = ST_RECLAIM;
      ST_RECLAIM:  st_d = ST_OWNED;
      default:     st_d = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_OWNED;
    else     st_q <= st_d;
  end

  assign state_o = st_q;
  assign ack_o   = (st_q == ST_RELEASED);
  assign oe_o    = (st_q != ST_RELEASED);
  assign hold_o  = (st_q == ST_RELEASED);
endmodule

// File: rtl/bho_tag_store.sv
module bho_tag_store #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int LINES = 8,
  localparam int IW   = $clog2(LINES),
  localparam int TW   = AW - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          snp_en_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic [DW-1:0] snp_data_i,
  input  logic          snp_upd_i,
  input  logic          fill_en_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_data_o,
  output logic          evt_valid_o,
  output logic [IW-1:0] evt_line_o,
  output logic          evt_upd_o
);
  logic [LINES-1:0] vld_q;
  logic [TW-1:0]    tag_q [LINES];
  logic [DW-1:0]    dat_q [LINES];

  logic [IW-1:0] snp_idx, fill_idx, lk_idx;
  logic [TW-1:0] snp_tag, fill_tag, lk_tag;
  logic          snp_hit;

  assign snp_idx  = snp_addr_i[IW-1:0];
  assign snp_tag  = snp_addr_i[AW-1:IW];
  assign fill_idx = fill_addr_i[IW-1:0];
  assign fill_tag = fill_addr_i[AW-1:IW];
  assign lk_idx   = lk_addr_i[IW-1:0];
  assign lk_tag   = lk_addr_i[AW-1:IW];

  assign snp_hit   = snp_en_i && vld_q[snp_idx] && (tag_q[snp_idx] == snp_tag);
  assign lk_hit_o  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data_o = dat_q[lk_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic snp_sel, fill_sel;
    assign snp_sel  = snp_hit && (snp_idx == IW'(g));
    assign fill_sel = fill_en_i && (fill_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
      end else if (snp_sel) begin
        vld_q[g] <= snp_upd_i;
      end else if (fill_sel) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (snp_sel && snp_upd_i) begin
        dat_q[g] <= snp_data_i;
      end else if (fill_sel) begin
        dat_q[g] <= fill_data_i;
        tag_q[g] <= fill_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_valid_o <= 1'b0;
      evt_line_o  <= '0;
      evt_upd_o   <= 1'b0;
    end else begin
      evt_valid_o <= snp_hit;
      evt_line_o  <= snp_idx;
      evt_upd_o   <= snp_upd_i;
    end
  end
endmodule

// File: rtl/bus_handover_ctrl.sv
module bus_handover_ctrl
  import bho_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int LINES = 8,
  localparam int IW   = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_req_i,
  input  logic          cyc_done_i,
  output logic          dma_ack_o,
  output logic          addr_oe_o,
  output logic          data_oe_o,
  output logic          ctrl_oe_o,
  output logic          cpu_hold_o,
  input  logic          snoop_wr_i,
  input  logic [AW-1:0] snoop_addr_i,
  input  logic [DW-1:0] snoop_data_i,
  input  logic          policy_upd_i,
  input  logic          fill_valid_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_hit_o,
  output logic [DW-1:0] lk_data_o,
  output logic          evt_valid_o,
  output logic [IW-1:0] evt_line_o,
  output logic          evt_upd_o
);
  bus_state_t state;
  logic       oe, released;

  bho_fsm i_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_i      (dma_req_i),
    .cyc_done_i (cyc_done_i),
    .state_o    (state),
    .ack_o      (dma_ack_o),
    .oe_o       (oe),
    .hold_o     (cpu_hold_o)
  );

  assign released  = (state == ST_RELEASED);
  assign addr_oe_o = oe;
  assign data_oe_o = oe;
  assign ctrl_oe_o = oe;

  bho_tag_store #(.AW(AW), .DW(DW), .LINES(LINES)) i_tags (
    .clk         (clk),
    .rst         (rst),
    .snp_en_i    (released && snoop_wr_i),
    .snp_addr_i  (snoop_addr_i),
    .snp_data_i  (snoop_data_i),
    .snp_upd_i   (policy_upd_i),
    .fill_en_i   (fill_valid_i && !released),
    .fill_addr_i (fill_addr_i),
    .fill_data_i (fill_data_i),
    .lk_addr_i   (lk_addr_i),
    .lk_hit_o    (lk_hit_o),
    .lk_data_o   (lk_data_o),
    .evt_valid_o (evt_valid_o),
    .evt_line_o  (evt_line_o),
    .evt_upd_o   (evt_upd_o)
  );
endmodule

// File: rtl/bho_checker.sv
module bho_checker (
  input logic clk,
  input logic rst,
  input logic dma_req_i,
  input logic cyc_done_i,
  input logic dma_ack_o,
  input logic addr_oe_o,
  input logic data_oe_o,
  input logic ctrl_oe_o,
  input logic cpu_hold_o,
  input logic snoop_wr_i,
  input logic evt_valid_o
);
  AST_RESET_OWNS: assert property (@(posedge clk) $fell(rst) |-> (!dma_ack_o && addr_oe_o && !evt_valid_o)); // R1
  AST_RELEASE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst) $rose(dma_ack_o) |-> ($past(cyc_done_i) && $past(dma_req_i))); // R2
  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (rst) dma_ack_o |-> (!addr_oe_o && !data_oe_o && !ctrl_oe_o)); // R3
  AST_ENABLES_WHEN_NO_ACK: assert property (@(posedge clk) disable iff (rst) !dma_ack_o |-> (addr_oe_o && data_oe_o && ctrl_oe_o)); // R4
  AST_RECLAIM_ON_DROP: assert property (@(posedge clk) disable iff (rst) $fell(dma_ack_o) |-> !$past(dma_req_i)); // R4
  AST_HOLD_MATCHES_RELEASE: assert property (@(posedge clk) disable iff (rst) cpu_hold_o == dma_ack_o); // R5
  AST_EVT_FROM_RELEASED_WRITE: assert property (@(posedge clk) disable iff (rst) $rose(evt_valid_o) |-> ($past(snoop_wr_i) && $past(dma_ack_o))); // R9
endmodule

bind bus_handover_ctrl bho_checker i_bho_checker (
  .clk         (clk),
  .rst         (rst),
  .dma_req_i   (dma_req_i),
  .cyc_done_i  (cyc_done_i),
  .dma_ack_o   (dma_ack_o),
  .addr_oe_o   (addr_oe_o),
  .data_oe_o   (data_oe_o),
  .ctrl_oe_o   (ctrl_oe_o),
  .cpu_hold_o  (cpu_hold_o),
  .snoop_wr_i  (snoop_wr_i),
  .evt_valid_o (evt_valid_o)
);

// File: tb/test_bus_handover_ctrl.sv
`timescale 1ns/1ps
module test_bus_handover_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, cd = 1'b0;
  logic        ack, aoe, doe, coe, hold;
  logic        swr = 1'b0, pol = 1'b0;
  logic [15:0] saddr = '0;
  logic [7:0]  sdata = '0;
  logic        fv = 1'b0;
  logic [15:0] faddr = '0;
  logic [7:0]  fdata = '0;
  logic [15:0] laddr = '0;
  logic        lhit;
  logic [7:0]  ldata;
  logic        ev, evu;
  logic [2:0]  evl;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_handover_ctrl i_bus_handover_ctrl (
    .clk(clk), .rst(rst), .dma_req_i(req), .cyc_done_i(cd), .dma_ack_o(ack),
    .addr_oe_o(aoe), .data_oe_o(doe), .ctrl_oe_o(coe), .cpu_hold_o(hold),
    .snoop_wr_i(swr), .snoop_addr_i(saddr), .snoop_data_i(sdata), .policy_upd_i(pol),
    .fill_valid_i(fv), .fill_addr_i(faddr), .fill_data_i(fdata),
    .lk_addr_i(laddr), .lk_hit_o(lhit), .lk_data_o(ldata),
    .evt_valid_o(ev), .evt_line_o(evl), .evt_upd_o(evu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_bus(input string tag, input logic e_ack);
    chk(tag, {ack, aoe, doe, coe, hold}, {e_ack, !e_ack, !e_ack, !e_ack, e_ack});
  endtask

  task automatic look(input string tag, input logic [15:0] a, input logic e_hit, input logic [7:0] e_data);
    laddr = a;
    #1;
    chk(tag, {lhit, (e_hit ? ldata : 8'h00)}, {e_hit, e_data});
  endtask

  // {req, cycle_done, expected ack}; bus enables and hold follow from ack
  localparam logic [2:0] VEC [14] = '{
    3'b000, 3'b100, 3'b100, 3'b111, 3'b101, 3'b000, 3'b000,
    3'b111, 3'b111, 3'b010, 3'b100, 3'b100, 3'b010, 3'b000
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    #1;
    chk_bus("R1 reset bus state", 1'b0);
    chk("R1 reset event", ev, 0);
    look("R1 line invalid after reset", 16'h1203, 1'b0, 8'h00);
    look("R1 line invalid after reset", 16'h0000, 1'b0, 8'h00);

    // R2 R3 R4 R5 handover vectors
    foreach (VEC[i]) begin
      req = VEC[i][2]; cd = VEC[i][1];
      step();
      chk_bus($sformatf("R2 R3 R4 R5 vector %0d", i), VEC[i][0]);
    end
    req = 1'b0; cd = 1'b0;

    // R11 fills while owning
    fv = 1'b1; faddr = 16'h1203; fdata = 8'hAA; step();
    faddr = 16'h4507; fdata = 8'h55; step();
    faddr = 16'h0001; fdata = 8'h11; step();
    fv = 1'b0;
    look("R11 fill line 3", 16'h1203, 1'b1, 8'hAA);
    look("R11 fill line 7", 16'h4507, 1'b1, 8'h55);

    // R9 snoop write while owning is ignored
    swr = 1'b1; saddr = 16'h1203; pol = 1'b0; step();
    swr = 1'b0;
    chk("R9 no event while owning", ev, 0);
    look("R9 line kept while owning", 16'h1203, 1'b1, 8'hAA);

    // release the bus
    req = 1'b1; cd = 1'b1; step(); cd = 1'b0;
    chk_bus("R3 released", 1'b1);

    // R11 fill while released ignored
    fv = 1'b1; faddr = 16'h0002; fdata = 8'h22; step(); fv = 1'b0;
    look("R11 fill ignored while released", 16'h0002, 1'b0, 8'h00);

    // R8 DMA read and miss
    swr = 1'b0; saddr = 16'h1203; step();
    chk("R8 read gives no event", ev, 0);
    swr = 1'b1; saddr = 16'h9903; step(); swr = 1'b0;
    chk("R8 miss gives no event", ev, 0);
    look("R8 line intact after read and miss", 16'h1203, 1'b1, 8'hAA);

    // R6 R10 invalidate
    swr = 1'b1; saddr = 16'h1203; pol = 1'b0; step(); swr = 1'b0;
    chk("R10 invalidate event", {ev, evl, evu}, {1'b1, 3'd3, 1'b0});
    look("R6 line invalidated", 16'h1203, 1'b0, 8'h00);
    step();
    chk("R10 event lasts one cycle", ev, 0);

    // R7 R12 back-to-back updates
    swr = 1'b1; pol = 1'b1; saddr = 16'h4507; sdata = 8'h99; step();
    chk("R12 first event", {ev, evl, evu}, {1'b1, 3'd7, 1'b1});
    saddr = 16'h0001; sdata = 8'h77; step(); swr = 1'b0;
    chk("R12 second event", {ev, evl, evu}, {1'b1, 3'd1, 1'b1});
    look("R7 updated line 7", 16'h4507, 1'b1, 8'h99);
    look("R7 updated line 1", 16'h0001, 1'b1, 8'h77);

    // overlap: request drop with snoop hit in the same clock
    req = 1'b0; swr = 1'b1; pol = 1'b0; saddr = 16'h0001; step(); swr = 1'b0;
    chk_bus("R4 reclaim with concurrent snoop", 1'b0);
    chk("R10 event from drop cycle", {ev, evl, evu}, {1'b1, 3'd1, 1'b0});
    look("R6 invalidated in drop cycle", 16'h0001, 1'b0, 8'h00);
    swr = 1'b1; saddr = 16'h4507; step(); swr = 1'b0;
    chk("R9 write after reclaim ignored", ev, 0);
    look("R9 line kept after reclaim", 16'h4507, 1'b1, 8'h99);

    // R1 reset clears filled lines
    rst = 1'b1; step(); rst = 1'b0; #1;
    look("R1 reset invalidates line", 16'h4507, 1'b0, 8'h00);
    chk_bus("R1 reset after activity", 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule